// File: doc/BRIEF.md
# Transmit Mailbox Outcome Flags

This block keeps the status flags of one transmit mailbox of a CAN controller. It sits between the bus protocol engine, which reports what happened to a frame as single-cycle event pulses, and a register interface, which issues a transmit request and writes a 4-bit flag register where writing one clears a bit. Four sticky flags come out: the attempt finished (done), it succeeded (ok), it lost arbitration (arb), or it failed with a bus error (err).

A small sequencer follows the mailbox through three named states. `ST_EMPTY` is the idle state. The transition `REQ_ACCEPT` leads from `ST_EMPTY` to `ST_QUEUED` when a request arrives. The transition `TX_BEGIN` leads from `ST_QUEUED` to `ST_ON_BUS` when the engine reports a start. The transition `FINISH` leads from either `ST_QUEUED` or `ST_ON_BUS` back to `ST_EMPTY` on any outcome or abort event. Hardware clears the flags when a new request is accepted or a transmission starts. A software clear of done also clears the three outcome flags. A hardware set always beats a clear in the same cycle.

Top module: `can_txmb_flags`

## Requirements
- R1: After reset all four flags read 0 and `busy_o` is 0.
- R2: A request in `ST_EMPTY` makes `busy_o` 1 from the next cycle and clears done, ok, arb and err.
- R3: A request while `busy_o` is 1 is ignored: the state and flags do not change because of it.
- R4: A start event in `ST_QUEUED` moves the mailbox to `ST_ON_BUS` (still busy) and clears arb and err. A start event in any other state is ignored.
- R5: An outcome event in `ST_QUEUED` or `ST_ON_BUS` returns the mailbox to `ST_EMPTY` and sets done together with exactly one outcome flag. If several outcome events arrive together, err is chosen first, then arb, then ok.
- R6: An abort completion in a busy state returns the mailbox to `ST_EMPTY` and sets done only.
- R7: Outcome and abort events in `ST_EMPTY` have no effect.
- R8: When `wr_en` is 1, a 1 in `wr_data` clears the matching flag (bit 0 done, bit 1 ok, bit 2 arb, bit 3 err). A 0 in a bit has no effect.
- R9: Writing 1 to bit 0 also clears ok, arb and err.
- R10: When a hardware set and a clear of the same flag fall in one cycle, the flag ends up 1.
- R11: At most one of ok, arb and err is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_req | input | 1 | Transmit request pulse from the register side |
| ev_start | input | 1 | Protocol engine: frame started on the bus |
| ev_ok | input | 1 | Protocol engine: frame sent successfully |
| ev_arb_lost | input | 1 | Protocol engine: arbitration lost |
| ev_err | input | 1 | Protocol engine: transmission error |
| ev_abort_done | input | 1 | Protocol engine: abort finished |
| wr_en | input | 1 | Write strobe for the flag register |
| wr_data | input | 4 | Write data; a 1 in a bit clears that flag |
| flags_o | output | 4 | {err, arb, ok, done} |
| busy_o | output | 1 | Mailbox holds a pending or active request |

## Verification
On every cycle, the assertions check the following:
- the outcome flags are mutually exclusive;
- a set of any flag wins over a clear in the same cycle;
- a clear with no set drops the flag, and a flag with neither holds its value;
- an accepted request empties all flags;
- a rising outcome flag is always accompanied by done.

Some properties are visible only through the bench's scenarios:
- the state walk from `ST_EMPTY` through `ST_QUEUED` to `ST_ON_BUS`;
- the err-over-arb-over-ok choice;
- that requests and outcome events in the wrong state are ignored;
- that writing zeros does nothing;
- the cascaded clear from bit 0.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;
    localparam int FLAG_W   = 4;
    localparam int F_DONE   = 0;
    localparam int F_OK     = 1;
    localparam int F_ARB    = 2;
    localparam int F_ERR    = 3;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_QUEUED = 2'd1,
        ST_ON_BUS = 2'd2
    } mb_state_e;

    typedef struct packed {
        logic fin;
        logic ok;
        logic arb;
        logic err;
    } outcome_t;
endpackage

// File: rtl/can_txmb_outcome.sv
module can_txmb_outcome
    import can_txmb_pkg::*;
(
    input  logic     armed,
    input  logic     ev_ok,
    input  logic     ev_arb_lost,
    input  logic     ev_err,
    input  logic     ev_abort_done,
    output outcome_t res
);
    always_comb begin
        res     = '0;
        res.fin = armed && (ev_ok || ev_arb_lost || ev_err || ev_abort_done);
        if (armed) begin
            if (ev_err)           res.err = 1'b1;
            else if (ev_arb_lost) res.arb = 1'b1;
            else if (ev_ok)       res.ok  = 1'b1;
        end
    end

    always_comb begin
        AST_SINGLE_OUTCOME: assert ($countones({res.ok, res.arb, res.err}) <= 1); // R5
    end
endmodule

// File: rtl/can_txmb_seq.sv
module can_txmb_seq
    import can_txmb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tx_req,
    input  logic      ev_start,
    input  logic      finish,
    output mb_state_e state,
    output logic      armed,
    output logic      req_take,
    output logic      start_take
);
    mb_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= nxt;
    end

    always_comb begin
        nxt        = state;
        armed      = 1'b0;
        req_take   = 1'b0;
        start_take = 1'b0;
        unique case (state)
            ST_EMPTY: begin
                if (tx_req) begin
                    req_take = 1'b1;
                    nxt      = ST_QUEUED;
                end
            end
            ST_QUEUED: begin
                armed = 1'b1;
                if (finish) nxt = ST_EMPTY;
                else if (ev_start) begin
                    start_take = 1'b1;
                    nxt        = ST_ON_BUS;
                end
            end
            ST_ON_BUS: begin
                armed = 1'b1;
                if (finish) nxt = ST_EMPTY;
            end
            default: nxt = ST_EMPTY;
        endcase
    end

    AST_FINISH_TO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && state != ST_EMPTY) |=> state == ST_EMPTY); // R5
    AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON_BUS && !finish) |=> state == ST_ON_BUS); // R3
endmodule

// File: rtl/can_txmb_flag.sv
module can_txmb_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q); // R10
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !q); // R8
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !set) |=> $stable(q)); // R8
endmodule

// File: rtl/can_txmb_flags.sv
module can_txmb_flags
    import can_txmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_req,
    input  logic              ev_start,
    input  logic              ev_ok,
    input  logic              ev_arb_lost,
    input  logic              ev_err,
    input  logic              ev_abort_done,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_data,
    output logic [FLAG_W-1:0] flags_o,
    output logic              busy_o
);
    mb_state_e         state;
    logic              armed, req_take, start_take;
    outcome_t          res;
    logic [FLAG_W-1:0] w1c, set_v, clr_v, q_v;

    can_txmb_seq u_seq (
        .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .ev_start(ev_start),
        .finish(res.fin), .state(state), .armed(armed),
        .req_take(req_take), .start_take(start_take)
    );

    can_txmb_outcome u_out (
        .armed(armed), .ev_ok(ev_ok), .ev_arb_lost(ev_arb_lost),
        .ev_err(ev_err), .ev_abort_done(ev_abort_done), .res(res)
    );

    always_comb begin
        w1c          = wr_en ? wr_data : '0;
        set_v        = '0;
        set_v[F_DONE] = res.fin;
        set_v[F_OK]   = res.ok;
        set_v[F_ARB]  = res.arb;
        set_v[F_ERR]  = res.err;
        clr_v[F_DONE] = req_take | w1c[F_DONE];
        clr_v[F_OK]   = req_take | w1c[F_DONE] | w1c[F_OK];
        clr_v[F_ARB]  = req_take | start_take | w1c[F_DONE] | w1c[F_ARB];
        clr_v[F_ERR]  = req_take | start_take | w1c[F_DONE] | w1c[F_ERR];
    end

    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        can_txmb_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set(set_v[i]), .clr(clr_v[i]), .q(q_v[i])
        );
    end

    assign flags_o = q_v;
    assign busy_o  = (state != ST_EMPTY);

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q_v[F_ERR:F_OK]) <= 1); // R11
    AST_REQ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !busy_o) |=> (flags_o == '0 && busy_o)); // R2
    AST_OUTCOME_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q_v[F_OK]) || $rose(q_v[F_ARB]) || $rose(q_v[F_ERR])) |-> q_v[F_DONE]); // R5
    AST_IDLE_EVENTS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !tx_req && !wr_en) |=> ($stable(flags_o) && !busy_o)); // R7
endmodule

// File: tb/sim_can_txmb_flags.sv
module sim_can_txmb_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_req = 0, ev_start = 0, ev_ok = 0, ev_arb_lost = 0, ev_err = 0, ev_abort_done = 0;
    logic       wr_en = 0;
    logic [3:0] wr_data = '0;
    logic [3:0] flags_o;
    logic       busy_o;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    int m_st = 0;          // 0 empty, 1 queued, 2 on bus
    logic [3:0] m_f = '0;  // {err, arb, ok, done}

    always #5 clk = ~clk;

    can_txmb_flags u0 (
        .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .ev_start(ev_start), .ev_ok(ev_ok),
        .ev_arb_lost(ev_arb_lost), .ev_err(ev_err), .ev_abort_done(ev_abort_done),
        .wr_en(wr_en), .wr_data(wr_data), .flags_o(flags_o), .busy_o(busy_o)
    );

    // Reference model of one clock edge from the requirements
    function automatic void model_step(input logic [5:0] ev, input logic we, input logic [3:0] wd);
        logic req = ev[0], st = ev[1], ok = ev[2], arb = ev[3], er = ev[4], ab = ev[5];
        logic fin, rq, sa;
        logic [3:0] w, s, c;
        fin = (m_st != 0) && (ok || arb || er || ab);
        rq  = (m_st == 0) && req;
        sa  = (m_st == 1) && st && !fin;
        w   = we ? wd : 4'd0;
        s[0] = fin;
        s[3] = fin && er;
        s[2] = fin && !er && arb;
        s[1] = fin && !er && !arb && ok;
        c[0] = rq | w[0];
        c[1] = rq | w[0] | w[1];
        c[2] = rq | sa | w[0] | w[2];
        c[3] = rq | sa | w[0] | w[3];
        for (int i = 0; i < 4; i++) m_f[i] = s[i] ? 1'b1 : (c[i] ? 1'b0 : m_f[i]);
        if (rq) m_st = 1; else if (fin) m_st = 0; else if (sa) m_st = 2;
    endfunction

    task automatic compare(input string tag);
        n_chk++;
        if (flags_o !== m_f || busy_o !== (m_st != 0)) begin
            n_fail++;
            $display("FAIL %s: flags=%b busy=%b expected flags=%b busy=%b",
                     tag, flags_o, busy_o, m_f, (m_st != 0));
        end
    endtask

    // ev = {abort, err, arb, ok, start, req}
    task automatic cyc(input logic [5:0] ev, input logic we, input logic [3:0] wd, input string tag);
        {ev_abort_done, ev_err, ev_arb_lost, ev_ok, ev_start, tx_req} = ev;
        wr_en = we; wr_data = wd;
        model_step(ev, we, wd);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    localparam logic [5:0] E_REQ = 6'b000001, E_START = 6'b000010, E_OK = 6'b000100,
                           E_ARB = 6'b001000, E_ERR = 6'b010000, E_ABT = 6'b100000;

    initial begin
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");
        cyc(E_REQ,   0, 4'h0, "R2 request accepted");
        cyc(E_START, 0, 4'h0, "R4 start to on-bus");
        cyc(E_OK,    0, 4'h0, "R5 success sets done+ok");
        cyc(6'd0,    1, 4'h0, "R8 writing zeros no effect");
        cyc(6'd0,    1, 4'h2, "R8 clear ok only");
        cyc(E_REQ,   0, 4'h0, "R2 request clears done");
        cyc(E_REQ,   0, 4'h0, "R3 request while busy ignored");
        cyc(E_START, 0, 4'h0, "R4 start");
        cyc(E_START, 0, 4'h0, "R4 start on bus ignored");
        cyc(E_ARB | E_OK, 0, 4'h0, "R5 arb beats ok");
        cyc(6'd0,    1, 4'h1, "R9 done clear cascades");
        cyc(E_REQ,   0, 4'h0, "R2 request");
        cyc(E_ERR | E_ARB, 1, 4'h9, "R10 set beats clear, R5 err first");
        cyc(E_OK | E_ERR | E_ABT, 0, 4'h0, "R7 events when empty ignored");
        cyc(6'd0,    1, 4'h8, "R8 clear err");
        cyc(E_REQ,   0, 4'h0, "R2 request");
        cyc(E_ABT,   0, 4'h0, "R6 abort sets done only");
        cyc(E_REQ,   0, 4'h0, "R2 request");
        cyc(E_START, 0, 4'h0, "R4 start");
        cyc(E_ABT,   1, 4'h1, "R10 abort done beats clear");
        for (int k = 0; k < 4000; k++) begin
            logic [5:0] ev;
            logic [3:0] wd;
            ev = 6'd0;
            if ($urandom_range(0, 3) == 0) ev[0] = 1'b1;
            if ($urandom_range(0, 2) == 0) ev[1] = 1'b1;
            for (int b = 2; b < 6; b++) if ($urandom_range(0, 7) == 0) ev[b] = 1'b1;
            wd = 4'($urandom);
            cyc(ev, ($urandom_range(0, 3) == 0), wd, "R11 random mix");
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule